// File: doc/BRIEF.md
# Protocol-Parameter Exchange Tracker

This block watches a sniffed smart-card byte stream and follows the optional protocol and parameter selection handshake. While the link sits idle between commands, a byte of 0xFF opens an exchange. The tracker then follows two back-to-back variable-length frames: the reader's request, then the card's response. It stores every field of both frames as it arrives.

A frame's format byte sets which optional fields are present. When the response is complete, the block raises a one-cycle update strobe and presents the negotiated rate codes (Fi and Di), so that the receiver's bit-rate divider can be retuned. An expired waiting time abandons the exchange. Check bytes are stored but are not verified.

Top module: `pts_tracker`

## Requirements
- R1: When no exchange is open, an exchange opens only on a valid byte equal to START_CODE (0xFF) while `idle_i` is high. Any other byte, and any byte while `idle_i` is low, leaves the block closed.
- R2: Field slots are numbered 0 (sync), 1 (format), 2..4 (optional 1..3) and 5 (check). Slot k of a frame is held at bits [8k+7:8k] of `req_o` or `rsp_o`. Outside an exchange, with no valid byte arriving, both frames hold their value.
- R3: Bits 4, 5 and 6 of a frame's format byte mark optional fields 1, 2 and 3 as present. An absent slot stays zero, and the next byte goes to the next present slot, or to the check slot.
- R4: The byte after the request's check byte is stored as the response sync byte, in `rsp_o` slot 0. It does not need to equal 0xFF.
- R5: Bits 7:4 of the response's optional field 1 become `fi_o`, and bits 3:0 become `di_o`. Both change only in the cycle in which `upd_o` is high.
- R6: The cycle after the response's check byte is accepted, `upd_o` is high for exactly one cycle and `in_xchg_o` is low. A later 0xFF while idle opens a new exchange.
- R7: A `wt_exp_i` pulse during an exchange closes it on the next cycle. No `upd_o` follows, `fi_o` and `di_o` stay unchanged, and a byte in the same cycle is not stored. Outside an exchange, `wt_exp_i` has no effect.
- R8: If the response has no optional field 1, `upd_o` still pulses, and `fi_o` and `di_o` keep their previous values.
- R9: When an exchange opens, `rsp_o` is all zero and `req_o` holds only the start byte in slot 0.
- R10: After reset, `fi_o` equals FI_RST (1), `di_o` equals DI_RST (1), and `req_o`, `rsp_o`, `upd_o` and `in_xchg_o` are zero.
- R11: `in_xchg_o` is high from the cycle after the start byte until completion or abort. During an exchange, `idle_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| idle_i | input | 1 | Link is waiting for a new command |
| wt_exp_i | input | 1 | Waiting time expired pulse |
| req_o | output | 48 | Request fields, slot k at [8k+7:8k] |
| rsp_o | output | 48 | Response fields, slot k at [8k+7:8k] |
| fi_o | output | 4 | Current rate code Fi |
| di_o | output | 4 | Current rate code Di |
| upd_o | output | 1 | Rate update strobe, one cycle |
| in_xchg_o | output | 1 | Exchange in progress |

## Verification
The bench builds the block with its default parameters: FI_RST and DI_RST at 1 and START_CODE at 0xFF. With these values, the reset rate codes are known and distinct from the negotiated ones, so a skipped or early rate load shows up. The exchanges cover format bytes with no optional fields, with only the third optional field, with only the first, and with all three, so every branch of the slot skipping is reached. An abort that coincides with a byte, and a response that lacks the rate field, reach the paths where the rate must not move.

// File: rtl/pts_track_pkg.sv
package pts_track_pkg;
  localparam int BYTE_W = 8;
  localparam int FLD_N  = 6;
  localparam int FLD_W  = 3;
  localparam int FRM_W  = FLD_N * BYTE_W;

  typedef enum logic [FLD_W-1:0] {
    F_SYNC = 3'd0,
    F_FMT  = 3'd1,
    F_OPT1 = 3'd2,
    F_OPT2 = 3'd3,
    F_OPT3 = 3'd4,
    F_CHK  = 3'd5
  } fld_e;

  // pres[0..2] = optional field 1..3 present
  function automatic fld_e next_fld(fld_e cur, logic [2:0] pres);
    fld_e n;
    case (cur)
      F_SYNC:  n = F_FMT;
      F_FMT:   n = pres[0] ? F_OPT1 : pres[1] ? F_OPT2 : pres[2] ? F_OPT3 : F_CHK;
      F_OPT1:  n = pres[1] ? F_OPT2 : pres[2] ? F_OPT3 : F_CHK;
      F_OPT2:  n = pres[2] ? F_OPT3 : F_CHK;
      F_OPT3:  n = F_CHK;
      default: n = F_SYNC;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pts_seq.sv
module pts_seq
  import pts_track_pkg::*;
#(
  parameter logic [BYTE_W-1:0] START_CODE = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              idle_i,
  input  logic              wt_exp_i,
  output logic              active_o,
  output logic              start_o,
  output logic              wr_o,
  output logic              wr_rsp_o,
  output logic [FLD_W-1:0]  wr_idx_o,
  output logic              done_o,
  output logic              rate_ld_o
);
  logic       active_q, is_rsp_q;
  fld_e       fld_q;
  logic [2:0] pres_q, pres_eff;
  logic       abort;

  assign start_o   = !active_q && byte_vld_i && idle_i && (byte_i == START_CODE);
  assign abort     = active_q && wt_exp_i;
  assign wr_o      = active_q && byte_vld_i && !wt_exp_i;
  assign wr_rsp_o  = is_rsp_q;
  assign wr_idx_o  = fld_q;
  assign done_o    = wr_o && is_rsp_q && (fld_q == F_CHK);
  assign rate_ld_o = wr_o && is_rsp_q && (fld_q == F_OPT1);
  assign active_o  = active_q;
  assign pres_eff  = (fld_q == F_FMT) ? byte_i[6:4] : pres_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      is_rsp_q <= 1'b0;
      fld_q    <= F_SYNC;
      pres_q   <= '0;
    end else if (abort || done_o) begin
      active_q <= 1'b0;
      is_rsp_q <= 1'b0;
      fld_q    <= F_SYNC;
    end else if (start_o) begin
      active_q <= 1'b1;
      is_rsp_q <= 1'b0;
      fld_q    <= F_FMT;
    end else if (wr_o) begin
      if (fld_q == F_FMT) pres_q <= byte_i[6:4];
      if (fld_q == F_CHK) is_rsp_q <= 1'b1;
      fld_q <= next_fld(fld_q, pres_eff);
    end
  end
endmodule

// File: rtl/pts_frames.sv
module pts_frames
  import pts_track_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              wr_rsp_i,
  input  logic [FLD_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [FRM_W-1:0]  req_o,
  output logic [FRM_W-1:0]  rsp_o
);
  logic [1:0][FRM_W-1:0] frm;

  for (genvar g = 0; g < 2; g++) begin : g_frm
    for (genvar k = 0; k < FLD_N; k++) begin : g_fld
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          q <= '0;
        else if (clr_i)
          q <= (g == 0 && k == 0) ? wdata_i : '0;
        else if (wr_i && (wr_rsp_i == 1'(g)) && (wr_idx_i == FLD_W'(k)))
          q <= wdata_i;
      end
      assign frm[g][k*BYTE_W +: BYTE_W] = q;
    end
  end

  assign req_o = frm[0];
  assign rsp_o = frm[1];
endmodule

// File: rtl/pts_rate.sv
module pts_rate
  import pts_track_pkg::*;
#(
  parameter logic [3:0] FI_RST = 4'd1,
  parameter logic [3:0] DI_RST = 4'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_byte_i,
  input  logic              apply_i,
  output logic [3:0]        fi_o,
  output logic [3:0]        di_o
);
  logic [3:0] fi_q, di_q, fi_pend, di_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fi_q    <= FI_RST;
      di_q    <= DI_RST;
      fi_pend <= FI_RST;
      di_pend <= DI_RST;
    end else begin
      if (clr_i) begin
        fi_pend <= fi_q;
        di_pend <= di_q;
      end else if (ld_i) begin
        fi_pend <= ld_byte_i[7:4];
        di_pend <= ld_byte_i[3:0];
      end
      if (apply_i) begin
        fi_q <= fi_pend;
        di_q <= di_pend;
      end
    end
  end

  assign fi_o = fi_q;
  assign di_o = di_q;
endmodule

// File: rtl/pts_tracker.sv
module pts_tracker
  import pts_track_pkg::*;
#(
  parameter logic [3:0]        FI_RST     = 4'd1,
  parameter logic [3:0]        DI_RST     = 4'd1,
  parameter logic [BYTE_W-1:0] START_CODE = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              idle_i,
  input  logic              wt_exp_i,
  output logic [FRM_W-1:0]  req_o,
  output logic [FRM_W-1:0]  rsp_o,
  output logic [3:0]        fi_o,
  output logic [3:0]        di_o,
  output logic              upd_o,
  output logic              in_xchg_o
);
  logic             start, wr, wr_rsp, done, rate_ld, active;
  logic [FLD_W-1:0] wr_idx;
  logic             upd_q;

  pts_seq #(.START_CODE(START_CODE)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .idle_i     (idle_i),
    .wt_exp_i   (wt_exp_i),
    .active_o   (active),
    .start_o    (start),
    .wr_o       (wr),
    .wr_rsp_o   (wr_rsp),
    .wr_idx_o   (wr_idx),
    .done_o     (done),
    .rate_ld_o  (rate_ld)
  );

  pts_frames u_frames (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start),
    .wr_i     (wr),
    .wr_rsp_i (wr_rsp),
    .wr_idx_i (wr_idx),
    .wdata_i  (byte_i),
    .req_o    (req_o),
    .rsp_o    (rsp_o)
  );

  pts_rate #(.FI_RST(FI_RST), .DI_RST(DI_RST)) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start),
    .ld_i      (rate_ld),
    .ld_byte_i (byte_i),
    .apply_i   (done),
    .fi_o      (fi_o),
    .di_o      (di_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= done;
  end

  assign upd_o     = upd_q;
  assign in_xchg_o = active;
endmodule

// File: rtl/pts_tracker_chk.sv
module pts_tracker_chk
  import pts_track_pkg::*;
#(
  parameter logic [BYTE_W-1:0] START_CODE = 8'hFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic              idle_i,
  input logic              wt_exp_i,
  input logic [FRM_W-1:0]  req_o,
  input logic [FRM_W-1:0]  rsp_o,
  input logic [3:0]        fi_o,
  input logic [3:0]        di_o,
  input logic              upd_o,
  input logic              in_xchg_o
);
  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_xchg_o && byte_vld_i && idle_i && byte_i == START_CODE) |=> in_xchg_o);

  p_no_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_xchg_o && !(byte_vld_i && idle_i && byte_i == START_CODE)) |=> !in_xchg_o);

  p_frames_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_xchg_o && !byte_vld_i) |=> ($stable(req_o) && $stable(rsp_o)));

  p_rate_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> ($stable(fi_o) && $stable(di_o)));

  p_upd_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> !in_xchg_o);

  p_upd_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_xchg_o && wt_exp_i) |=> (!in_xchg_o && !upd_o));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_xchg_o) |-> (rsp_o == '0 && req_o[FRM_W-1:BYTE_W] == '0
                          && req_o[BYTE_W-1:0] == START_CODE));
endmodule

bind pts_tracker pts_tracker_chk #(.START_CODE(START_CODE)) u_chk (.*);

// File: tb/pts_tracker_test.sv
module pts_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        idle_i = 1'b1;
  logic        wt_exp_i = 1'b0;
  logic [47:0] req_o, rsp_o;
  logic [3:0]  fi_o, di_o;
  logic        upd_o, in_xchg_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pts_tracker uut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .idle_i(idle_i), .wt_exp_i(wt_exp_i), .req_o(req_o), .rsp_o(rsp_o),
    .fi_o(fi_o), .di_o(di_o), .upd_o(upd_o), .in_xchg_o(in_xchg_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_vld_i = 1'b1;
    byte_i     = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic pulse_wt();
    @(negedge clk);
    wt_exp_i = 1'b1;
    @(negedge clk);
    wt_exp_i = 1'b0;
  endtask

  task automatic push_upd(input logic [3:0] fi, input logic [3:0] di);
    exp_q.push_back({fi, di});
  endtask

  // scoreboard monitor: each update strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_ni && upd_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected upd_o", 64'(upd_o), 64'd0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk({fi_o, di_o} == e, "R5 fi/di at upd_o", 64'({fi_o, di_o}), 64'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(fi_o == 4'd1 && di_o == 4'd1, "R10 reset fi/di", 64'({fi_o, di_o}), 64'h11);
    chk(req_o == '0 && rsp_o == '0, "R10 reset frames", 64'(req_o | rsp_o), 64'd0);
    chk(!upd_o && !in_xchg_o, "R10 reset flags", 64'({upd_o, in_xchg_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 no start when not idle, or on another byte
    idle_i = 1'b0;
    send(8'hFF);
    chk(!in_xchg_o, "R1 FF not idle", 64'(in_xchg_o), 64'd0);
    idle_i = 1'b1;
    send(8'h3B);
    chk(!in_xchg_o, "R1 non-FF byte", 64'(in_xchg_o), 64'd0);
    // R7 wt_exp outside exchange ignored
    pulse_wt();
    chk(!in_xchg_o && req_o == '0, "R7 wt_exp idle", 64'(in_xchg_o), 64'd0);

    // exchange A: only optional field 1 present
    send(8'hFF);
    chk(in_xchg_o, "R11 opens", 64'(in_xchg_o), 64'd1);
    chk(req_o == 48'hFF && rsp_o == '0, "R9 clear on open", 64'(req_o), 64'hFF);
    send(8'h10); send(8'h96); send(8'h79);
    chk(req_o == 48'h79_00_00_96_10_FF, "R3 req opt1 only", 64'(req_o), 64'h79000096_10FF);
    chk(in_xchg_o && rsp_o == '0, "R4 awaiting response", 64'(rsp_o), 64'd0);
    chk(fi_o == 4'd1 && di_o == 4'd1, "R5 no early rate", 64'({fi_o, di_o}), 64'h11);
    idle_i = 1'b0;  // R11 ignored during exchange
    send(8'hFF); send(8'h10); send(8'h96);
    chk(fi_o == 4'd1, "R5 fi held before end", 64'(fi_o), 64'd1);
    push_upd(4'd9, 4'd6);
    send(8'h79);
    chk(!in_xchg_o, "R6 closes", 64'(in_xchg_o), 64'd0);
    chk(rsp_o == 48'h79_00_00_96_10_FF, "R2 rsp slots", 64'(rsp_o), 64'h79000096_10FF);
    chk(fi_o == 4'd9 && di_o == 4'd6, "R5 new fi/di", 64'({fi_o, di_o}), 64'h96);
    idle_i = 1'b1;

    // exchange B: all optional fields, rearm
    send(8'hFF);
    chk(in_xchg_o && rsp_o == '0, "R6 rearm + R9 clear", 64'(in_xchg_o), 64'd1);
    send(8'h70); send(8'h11); send(8'h22); send(8'h33); send(8'h8C);
    chk(req_o == 48'h8C_33_22_11_70_FF, "R2 req all fields", 64'(req_o), 64'h8C332211_70FF);
    send(8'hFE);  // R4: response sync byte taken as-is
    chk(rsp_o == 48'hFE, "R4 rsp sync slot", 64'(rsp_o), 64'hFE);
    send(8'h70); send(8'h13); send(8'h44); send(8'h55);
    push_upd(4'd1, 4'd3);
    send(8'hCC);
    chk(rsp_o == 48'hCC_55_44_13_70_FE, "R2 rsp all fields", 64'(rsp_o), 64'hCC554413_70FE);
    chk(fi_o == 4'd1 && di_o == 4'd3, "R5 fi/di B", 64'({fi_o, di_o}), 64'h13);

    // exchange C: only optional field 3, response has no field 1
    send(8'hFF); send(8'h40); send(8'hAA); send(8'hBB);
    chk(req_o == 48'hBB_AA_00_00_40_FF, "R3 req opt3 only", 64'(req_o), 64'hBBAA0000_40FF);
    send(8'hFF); send(8'h00);
    push_upd(4'd1, 4'd3);
    send(8'h5A);
    chk(rsp_o == 48'h5A_00_00_00_00_FF, "R3 rsp no options", 64'(rsp_o), 64'h5A000000_00FF);
    chk(fi_o == 4'd1 && di_o == 4'd3 && !in_xchg_o, "R8 rate kept", 64'({fi_o, di_o}), 64'h13);

    // exchange D: abort with coincident byte
    send(8'hFF); send(8'h10);
    @(negedge clk);
    byte_vld_i = 1'b1; byte_i = 8'h95; wt_exp_i = 1'b1;
    @(negedge clk);
    byte_vld_i = 1'b0; wt_exp_i = 1'b0;
    chk(!in_xchg_o, "R7 abort closes", 64'(in_xchg_o), 64'd0);
    chk(req_o == 48'h10FF, "R7 byte dropped on abort", 64'(req_o), 64'h10FF);
    repeat (2) @(negedge clk);
    chk(fi_o == 4'd1 && di_o == 4'd3, "R7 rate kept on abort", 64'({fi_o, di_o}), 64'h13);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all updates seen", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule